// File: doc/BRIEF.md
# Bandwidth Gap Traffic Regulator

This block paces the traffic of one logical, unidirectional link. An application hands it packet descriptors (link id, length, sequence number) over a valid/ready push port, in any pattern it likes. The block stores them in a small FIFO. It lets them out toward a downstream scheduler at a rate of no more than one descriptor per configured gap. Time is measured in strobes on a tick input, where one strobe stands for one microsecond. Gap lengths such as 1000, 2000 or 4000 ticks are typical.

A gap counter advances only on tick strobes. Each time the counter completes a gap, the block becomes eligible to send. While it is eligible and the FIFO holds a descriptor, the head descriptor is presented on the pop port. Eligibility is withdrawn when that descriptor is taken. If a gap completes while the FIFO is empty, eligibility is kept. The next descriptor to arrive then leaves at once instead of waiting for a further gap.

At ingress, descriptors whose length lies outside an inclusive configured window are dropped, and a sticky error flag is raised.

Top module: `bag_shaper`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and len_err is 0.
- R2: The gap counter restarts at reset. Eligibility is first granted once gap_len tick strobes have been counted, so no descriptor leaves before gap_len ticks have passed since reset.
- R3: Let the tick count since reset be divided by gap_len, rounded down, to give the index of the gap window. Successive descriptors leave in strictly increasing windows, so at most one leaves per gap, however bursty the input.
- R4: Descriptors leave in arrival order, with id, length and sequence fields unchanged.
- R5: A descriptor accepted with in_len < min_len or in_len > max_len is discarded and sets len_err. The bounds themselves are accepted. len_err stays 1 until reset.
- R6: If a gap has completed while the FIFO was empty, a descriptor accepted at a clock edge makes out_valid 1 right after that edge.
- R7: in_ready is 0 while DEPTH descriptors are stored. A descriptor offered while in_ready is 0 is not stored.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and the output fields stay stable. A gap that completes during the wait does not let a second descriptor leave in the same window.
- R9: The gap counter advances only on clock edges where tick is 1. With tick held at 0, no descriptor leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-microsecond time strobe |
| gap_len | input | GAP_W | Gap length in ticks |
| min_len | input | LEN_W | Smallest legal length (inclusive) |
| max_len | input | LEN_W | Largest legal length (inclusive) |
| in_valid | input | 1 | Push descriptor valid |
| in_ready | output | 1 | Push port can take a descriptor |
| in_id | input | ID_W | Pushed link id |
| in_len | input | LEN_W | Pushed length |
| in_seq | input | SEQ_W | Pushed sequence number |
| out_valid | output | 1 | Pop descriptor valid |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_id | output | ID_W | Released link id |
| out_len | output | LEN_W | Released length |
| out_seq | output | SEQ_W | Released sequence number |
| len_err | output | 1 | Sticky flag for a dropped out-of-range length |

## Verification
Errors in the gap counter or the eligibility bit show at the pop port as soon as a second descriptor is queued. A release then falls into the same tick window as the one before it, or before the first window closes. Alternatively, a queued descriptor is held back past a completed gap. An error in the FIFO pointers or the occupancy count shows as a wrong field or a wrong order on the very next release. It can also show as in_ready staying high with DEPTH entries stored. A missed drop shows as an extra descriptor with no match, and len_err fails to rise on the cycle after the bad push.

// File: rtl/bag_shaper.sv
module bag_shaper #(
  parameter int ID_W  = 8,
  parameter int LEN_W = 12,
  parameter int SEQ_W = 16,
  parameter int GAP_W = 13,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_id,
  input  logic [LEN_W-1:0] in_len,
  input  logic [SEQ_W-1:0] in_seq,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_id,
  output logic [LEN_W-1:0] out_len,
  output logic [SEQ_W-1:0] out_seq,
  output logic             len_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int DW = ID_W + LEN_W + SEQ_W;
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic [GAP_W-1:0] gcnt;
  logic             elig;

  wire             len_ok   = (in_len >= min_len) && (in_len <= max_len);
  wire             in_fire  = in_valid && in_ready;
  wire             wr_en    = in_fire && len_ok;
  wire             out_fire = out_valid && out_ready;
  wire [GAP_W:0]   gnext    = {1'b0, gcnt} + 1'b1;
  wire             expire   = tick && (gnext >= {1'b0, gap_len});

  assign in_ready  = (count != FULL);
  assign out_valid = elig && (count != '0);
  assign {out_id, out_len, out_seq} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt <= '0;
      elig <= 1'b0;
    end else begin
      if (tick) gcnt <= expire ? '0 : gnext[GAP_W-1:0];
      if (expire)        elig <= 1'b1;
      else if (out_fire) elig <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= {in_id, in_len, in_seq};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      len_err <= 1'b0;
    end else begin
      if (wr_en)    wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (out_fire) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, out_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (in_fire && !len_ok) len_err <= 1'b1;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (count <= $past(count)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  assert_bad_len_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !len_ok) |=> len_err);

  assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_id, out_len, out_seq})));

  assert_one_per_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !expire) |=> !out_valid);
endmodule

// File: tb/bag_shaper_tb.sv
module bag_shaper_tb_top;
  localparam int ID_W = 8, LEN_W = 12, SEQ_W = 16, GAP_W = 13, DEPTH = 8;
  localparam int DW = ID_W + LEN_W + SEQ_W;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [GAP_W-1:0] gap_len = 13'd4;
  logic [LEN_W-1:0] min_len = 12'd64, max_len = 12'd1500;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [ID_W-1:0] in_id = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic [SEQ_W-1:0] in_seq = '0;
  logic in_ready, out_valid, len_err;
  logic [ID_W-1:0] out_id;
  logic [LEN_W-1:0] out_len;
  logic [SEQ_W-1:0] out_seq;

  bag_shaper #(.ID_W(ID_W), .LEN_W(LEN_W), .SEQ_W(SEQ_W), .GAP_W(GAP_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gap_len(gap_len), .min_len(min_len),
    .max_len(max_len), .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
    .in_len(in_len), .in_seq(in_seq), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_len(out_len), .out_seq(out_seq), .len_err(len_err));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [DW-1:0] expq[$];
  int tcnt = 0, last_w = 0, phase = 0;
  bit tick_en = 1'b0, stalled = 1'b0, done = 1'b0;
  logic [DW-1:0] stall_val;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tick  = tick_en && (phase == 2);
    phase = (phase == 2) ? 0 : phase + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) tcnt <= 0;
    else if (tick) tcnt <= tcnt + 1;
  end

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (stalled) begin
        chk(out_valid && {out_id, out_len, out_seq} == stall_val, "R8 hold",
            longint'({out_id, out_len, out_seq}), longint'(stall_val));
      end
      stalled = 1'b0;
      if (out_valid && out_ready) begin
        int w;
        w = tcnt / int'(gap_len);
        chk(w > last_w, "R2/R3 gap window", w, last_w + 1);
        last_w = w;
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected release", longint'(out_seq), -1);
        end else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          chk({out_id, out_len, out_seq} == e, "R4 order/fields",
              longint'({out_id, out_len, out_seq}), longint'(e));
        end
      end else if (out_valid) begin
        stalled = 1'b1;
        stall_val = {out_id, out_len, out_seq};
      end
    end
  end

  task automatic do_reset(input int gap);
    @(negedge clk);
    rst_n = 1'b0; gap_len = GAP_W'(gap); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    expq.delete(); last_w = 0; stalled = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic push(input int id, input int len, input int seq);
    in_valid = 1'b1; in_id = ID_W'(id); in_len = LEN_W'(len); in_seq = SEQ_W'(seq);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (len >= int'(min_len) && len <= int'(max_len))
      expq.push_back({ID_W'(id), LEN_W'(len), SEQ_W'(seq)});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while (expq.size() != 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R4 drained", expq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(4);
    #2;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(len_err == 1'b0, "R1 len_err", len_err, 0);

    // R9 no ticks, no release
    @(negedge clk);
    out_ready = 1'b1; tick_en = 1'b0;
    push(1, 100, 10);
    repeat (40) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R9 no tick no release", out_valid, 0);
    @(negedge clk);
    tick_en = 1'b1;
    // R3/R4 burst
    for (int i = 0; i < 5; i++) push(2, 200 + i, 20 + i);
    drain(400);

    // R5 length window
    push(3, 63, 30);
    #2;
    chk(len_err == 1'b1, "R5 short flagged", len_err, 1);
    push(3, 1501, 31);
    push(3, 64, 32);
    push(3, 1500, 33);
    drain(400);
    #2;
    chk(len_err == 1'b1, "R5 sticky", len_err, 1);

    // R7 full
    do_reset(5);
    @(negedge clk);
    out_ready = 1'b0; tick_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) push(4, 300 + i, 40 + i);
    #2;
    chk(in_ready == 1'b0, "R7 full", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b1; in_id = 8'd99; in_len = 12'd500; in_seq = 16'd999;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1; tick_en = 1'b1;
    drain(1000);
    repeat (40) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R7 blocked item not stored", out_valid, 0);

    // R8 backpressure across gaps
    do_reset(4);
    @(negedge clk);
    out_ready = 1'b0; tick_en = 1'b1;
    push(5, 400, 50);
    push(5, 401, 51);
    repeat (60) @(negedge clk);
    #2;
    chk(out_valid == 1'b1, "R8 waiting", out_valid, 1);
    @(negedge clk);
    out_ready = 1'b1;
    drain(400);

    // R6 held eligibility
    do_reset(4);
    @(negedge clk);
    out_ready = 1'b1; tick_en = 1'b1;
    while (tcnt < 14) @(negedge clk);
    push(6, 600, 60);
    #2;
    chk(out_valid == 1'b1, "R6 immediate release", out_valid, 1);
    drain(50);

    // R2 long gap
    do_reset(1000);
    @(negedge clk);
    out_ready = 1'b1; tick_en = 1'b1;
    push(7, 700, 70);
    push(7, 701, 71);
    push(7, 702, 72);
    repeat (100) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R2 no early release", out_valid, 0);
    drain(15000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule